// File: doc/BRIEF.md
# Dual-Quantized Log-Tanh Check Node

This block is the check-node processor of a sum-product LDPC decoder for one parity row of degree `DC`. Each cycle it can accept a full vector of `DC` signed variable-to-check messages. It returns the `DC` check-to-variable messages for that row. Each output is built from the other edges only: its magnitude comes from a log-tanh domain sum with the edge's own term removed, and its sign is the product of the other edges' signs.

The log-tanh transform Phi(x) = ln((e^x + 1)/(e^x - 1)) is its own inverse, so one function fills both lookups. The two sides of the lookups use different number formats of the same word length. Outside the lookups, messages have coarse resolution and a wide range: two's complement with `OUTER_FRAC` fraction bits, which is Q4.2 by default and Q6.0 when `OUTER_FRAC` is 0. Inside, values have fine resolution in Q1.5. This keeps small log-tanh values from collapsing to zero. All lookup contents are computed at elaboration from the transform.

The datapath is a three-register pipeline that takes a new vector every cycle. Variable-node work, message storage and iteration control are not part of this block.

Top module: `dq_check_node`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first result, `out_vld` is 0 and `out_msg` is all zeros.
- R2: A vector presented with `in_vld` high before clock edge n produces `out_vld` high after edge n+2, which is a latency of three cycles. Back-to-back vectors are all accepted and returned in order, one per cycle.
- R3: Edge k's message sits at bits [k*W +: W] of each vector. Output magnitude on edge k = Phi2(min(S - T[k], 31)), where T[j] = Phi1(|x_j|) and S is the sum of all T[j]. Phi1 maps an outer magnitude code m (value m/2^OUTER_FRAC) to an inner code (value c/32). Phi2 maps an inner code to an outer magnitude code.
- R4: Before Phi1, an input magnitude is saturated to code 31, so the input code -32 is treated as magnitude 31. In both lookups, an input code of 0 maps to code 31. Every other code maps to round-half-up(Phi(value) * 2^frac_out), clipped to 31.
- R5: The sign of output k is the XOR of the sign bits (bit W-1) of all inputs except k. An input of value zero counts as positive.
- R6: Outputs are two's complement with the same outer format as the inputs. A zero magnitude is always output as code 0, and the most negative code (-32) is never output.
- R7: When the sum of the other edges' inner terms exceeds 31 (0.96875), it is clipped to 31 before the second lookup. For example, with every input equal to zero each output becomes Phi2(31) = +3 in Q4.2.
- R8: On cycles that carry no result, `out_msg` keeps the last result.
- R9: With `OUTER_FRAC` = 0, inputs and outputs are integers (Q6.0), while the inner Q1.5 format is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input vector valid |
| in_msg | input | DC*W | Variable-to-check messages, edge k at [k*W +: W] |
| out_vld | output | 1 | Output vector valid |
| out_msg | output | DC*W | Check-to-variable messages, edge k at [k*W +: W] |

## Verification
Some behaviours are checked by assertions on every cycle:
- the valid bit walks through the three pipeline stages with no loss and no spurious result;
- the output holds between results;
- no edge ever emits the most negative code.

The values themselves can only be shown by the bench scenarios, which compare every edge against a model built from the transform definition. These scenarios include:
- all-zero rows that drive the inner clip;
- rows with the input code -32;
- rows with single and multiple negative edges;
- rows whose reliable inputs shrink to inner code 0;
- random rows of small, large and mixed magnitudes.

The integer outer format is exercised by a second instance fed the same vectors.

// File: rtl/dq_check_node.sv
module dq_check_node #(
  parameter int DC         = 32,
  parameter int W          = 6,
  parameter int OUTER_FRAC = 2,
  parameter int INNER_FRAC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [DC*W-1:0] in_msg,
  output logic            out_vld,
  output logic [DC*W-1:0] out_msg
);
  localparam int MW   = W - 1;
  localparam int MAXC = (1 << MW) - 1;
  localparam int SW   = MW + $clog2(DC) + 1;

  function automatic int phi_code(int code, int fin, int fout);
    real x, y, s;
    if (code == 0) return MAXC;
    x = real'(code) / real'(1 << fin);
    y = $ln(($exp(x) + 1.0) / ($exp(x) - 1.0));
    s = $floor(y * real'(1 << fout) + 0.5);
    if (s > real'(MAXC)) return MAXC;
    return int'(s);
  endfunction

  logic [MW-1:0] fwd_rom [MAXC+1];
  logic [MW-1:0] inv_rom [MAXC+1];

  for (genvar c = 0; c <= MAXC; c++) begin : g_rom
    localparam int FV = phi_code(c, OUTER_FRAC, INNER_FRAC);
    localparam int IV = phi_code(c, INNER_FRAC, OUTER_FRAC);
    assign fwd_rom[c] = MW'(FV);
    assign inv_rom[c] = MW'(IV);
  end

  logic          v1, v2;
  logic [MW-1:0] t1 [DC];
  logic [MW-1:0] t2 [DC];
  logic [DC-1:0] s1, s2;
  logic          p2;
  logic [SW-1:0] sum2;
  logic [SW-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      v1      <= in_vld;
      v2      <= v1;
      out_vld <= v2;
    end
  end

  for (genvar k = 0; k < DC; k++) begin : g_in
    logic [W-1:0]  x;
    logic [W-1:0]  ax;
    logic [MW-1:0] m;
    assign x  = in_msg[k*W +: W];
    assign ax = x[W-1] ? (~x + 1'b1) : x;
    assign m  = ax[W-1] ? MW'(MAXC) : ax[MW-1:0];
    always_ff @(posedge clk) begin
      t1[k] <= fwd_rom[m];
      s1[k] <= x[W-1];
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < DC; j++) acc = acc + SW'(t1[j]);
  end

  always_ff @(posedge clk) begin
    sum2 <= acc;
    t2   <= t1;
    s2   <= s1;
    p2   <= ^s1;
  end

  for (genvar k = 0; k < DC; k++) begin : g_out
    logic [SW-1:0] marg;
    logic [MW-1:0] ms;
    logic [MW-1:0] mo;
    logic          sg;
    logic [W-1:0]  val;
    assign marg = sum2 - SW'(t2[k]);
    assign ms   = (marg > SW'(MAXC)) ? MW'(MAXC) : marg[MW-1:0];
    assign mo   = inv_rom[ms];
    assign sg   = p2 ^ s2[k];
    assign val  = sg ? (~{1'b0, mo} + 1'b1) : {1'b0, mo};
    always_ff @(posedge clk) begin
      if (!rst_n)  out_msg[k*W +: W] <= '0;
      else if (v2) out_msg[k*W +: W] <= val;
    end

    AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_msg[k*W +: W] != {1'b1, {MW{1'b0}}})); // R6
  end

  AST_STAGE_A: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> v1); // R2
  AST_STAGE_B: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> v2); // R2
  AST_STAGE_C: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |=> out_vld); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !v1); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> $stable(out_msg)); // R8
endmodule

// File: tb/sim_dq_check_node.sv
module sim_dq_check_node;
  localparam int DC = 32;
  localparam int W  = 6;
  localparam int NV = 1024;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_vld;
  logic [DC*W-1:0] in_msg;
  logic            out_vld, out_vld_i;
  logic [DC*W-1:0] out_msg, out_msg_i;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int wr = 0, rd = 0;
  logic [DC*W-1:0] exp_q [NV];
  logic [DC*W-1:0] exp_i [NV];
  int              pcyc  [NV];
  string           tag_q [NV];
  logic [DC*W-1:0] last_q, last_i;
  logic            seen = 1'b0;
  bit              done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dq_check_node #(.DC(DC), .W(W), .OUTER_FRAC(2), .INNER_FRAC(5)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_msg(in_msg),
    .out_vld(out_vld), .out_msg(out_msg));

  dq_check_node #(.DC(DC), .W(W), .OUTER_FRAC(0), .INNER_FRAC(5)) u1 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_msg(in_msg),
    .out_vld(out_vld_i), .out_msg(out_msg_i));

  function automatic int phi(int code, int fin, int fout);
    real x, y, s;
    if (code == 0) return 31;
    x = real'(code) / real'(1 << fin);
    y = $ln(($exp(x) + 1.0) / ($exp(x) - 1.0));
    s = $floor(y * real'(1 << fout) + 0.5);
    return (s > 31.0) ? 31 : int'(s);
  endfunction

  function automatic logic [DC*W-1:0] model(logic [DC*W-1:0] v, int fin);
    int t [DC];
    bit sg [DC];
    int total = 0;
    bit par = 0;
    logic [DC*W-1:0] r = '0;
    for (int k = 0; k < DC; k++) begin
      logic signed [W-1:0] x;
      int m;
      x = v[k*W +: W];
      sg[k] = (x < 0);
      m = sg[k] ? -int'(x) : int'(x);
      if (m > 31) m = 31;
      t[k] = phi(m, fin, 5);
      total += t[k];
      par ^= sg[k];
    end
    for (int k = 0; k < DC; k++) begin
      int m, o;
      m = total - t[k];
      if (m > 31) m = 31;
      o = phi(m, 5, fin);
      r[k*W +: W] = (par ^ sg[k]) ? W'(-o) : W'(o);
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (rd == wr) chk(0, "R2", "unexpected out_vld, queue", rd, wr);
        else begin
          chk(cyc == pcyc[rd] + 3, "R2", "latency cycles", cyc - pcyc[rd], 3);
          chk(out_vld_i == 1'b1, "R9", "integer-format valid", out_vld_i, 1);
          for (int k = 0; k < DC; k++) begin
            if (out_msg[k*W +: W] != exp_q[rd][k*W +: W]) begin
              chk(0, tag_q[rd], $sformatf("edge %0d Q4.2", k),
                  out_msg[k*W +: W], exp_q[rd][k*W +: W]);
              break;
            end
            if (k == DC-1) chk(1, tag_q[rd], "", 0, 0);
          end
          for (int k = 0; k < DC; k++) begin
            if (out_msg_i[k*W +: W] != exp_i[rd][k*W +: W]) begin
              chk(0, "R9", $sformatf("edge %0d Q6.0", k),
                  out_msg_i[k*W +: W], exp_i[rd][k*W +: W]);
              break;
            end
            if (k == DC-1) chk(1, "R9", "", 0, 0);
          end
          for (int k = 0; k < DC; k++)
            if (out_msg[k*W +: W] == 6'b100000)
              chk(0, "R6", "most negative code", out_msg[k*W +: W], 0);
          rd++;
        end
        last_q = out_msg;
        last_i = out_msg_i;
        seen   = 1'b1;
      end else if (seen) begin
        chk(out_msg == last_q && out_msg_i == last_i, "R8", "held output changed",
            out_msg[W-1:0], last_q[W-1:0]);
      end
    end
  end

  task automatic send(logic [DC*W-1:0] v, string req);
    @(negedge clk);
    in_vld = 1'b1;
    in_msg = v;
    exp_q[wr] = model(v, 2);
    exp_i[wr] = model(v, 0);
    pcyc[wr]  = cyc;
    tag_q[wr] = req;
    wr++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_msg = '0;
    end
  endtask

  function automatic logic [DC*W-1:0] fill(logic [W-1:0] c);
    logic [DC*W-1:0] r;
    for (int k = 0; k < DC; k++) r[k*W +: W] = c;
    return r;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DC*W-1:0] v;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; in_vld = 1'b0; in_msg = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_vld == 0 && out_vld_i == 0, "R1", "out_vld in reset", out_vld, 0);
    chk(out_msg == '0 && out_msg_i == '0, "R1", "out_msg in reset", out_msg[W-1:0], 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 0 && out_msg == '0, "R1", "state after reset", out_vld, 0);

    send(fill(6'd31), "R3");           // R3: strong inputs, inner terms 0
    idle(4);
    send(fill(6'd0), "R7");            // R7: zero inputs, inner clip, +3
    idle(4);
    v = fill(6'd31); v[5*W +: W] = 6'b100000;
    send(v, "R4");                     // R4: -32 saturates to magnitude 31
    v = fill(6'd20); v[0 +: W] = 6'd0;
    send(v, "R4");                     // R4: one zero input maps to max code
    v = fill(6'd12); v[3*W +: W] = -6'sd7; v[9*W +: W] = -6'sd1;
    send(v, "R5");                     // R5: two negatives
    v = fill(6'd9); v[31*W +: W] = -6'sd4;
    send(v, "R5");                     // R5: one negative
    v = fill(6'd0); v[7*W +: W] = -6'sd2;
    send(v, "R6");                     // R6: negative zero must not appear
    idle(5);

    for (int n = 0; n < 360; n++) begin
      int mode = $urandom_range(0, 2);
      for (int k = 0; k < DC; k++) begin
        case (mode)
          0: v[k*W +: W] = W'($urandom_range(0, 63));
          1: v[k*W +: W] = W'($urandom_range(0, 6) - 3);
          default: v[k*W +: W] = ($urandom_range(0, 1) != 0) ? 6'd31 - W'($urandom_range(0, 8))
                                                              : 6'd33 + W'($urandom_range(0, 8));
        endcase
      end
      send(v, (mode == 1) ? "R7" : "R3");  // R3/R7 random rows
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(8);
    chk(rd == wr, "R2", "results returned", rd, wr);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule